// File: doc/BRIEF.md
# Toggle-Held State Register for a Small State Machine

The block holds the state vector of a small finite state machine with two primary inputs, two state bits and one output. The state bits do not sit in plain load-every-cycle registers. Each bit is a toggle cell whose toggle input is always asserted. The bit inverts only when its own update strobe fires. That strobe is the bit's clock function: it is true only when the bit's computed next value differs from its stored value. A rewrite of the same value, whether zero to zero or one to one, makes no transition. The update decision comes out of the next-state logic itself, so no separate gating controller exists.

The primary inputs pass through a reset-cleared synchroniser of `SYNC_STAGES` flops before they reach the next-state and output logic. A change in the middle of a clock period therefore cannot reach a strobe. Everything runs on the single system clock: a toggle cell is written as `q <= q ^ strobe`, and the strobe and next value are signals inside the clock domain. The per-bit strobes are exported. A wrapping counter adds up how many strobes fired, so a testbench can compare the real update activity with that of a conventional register clocked every cycle.

Top module: `tsr_top`

## Requirements
- R1: While `rst` is high, `upd_strb` is 2'b00. At the next rising edge, `state_q` becomes 2'b00, `upd_cnt` becomes 0 and every synchroniser stage becomes 2'b00.
- R2: A change on `in_raw` reaches the next-state logic after exactly `SYNC_STAGES` (default 2) rising edges. From reset with `in_raw` = 2'b01, the strobe `upd_strb` = 2'b01 appears in the cycle after the second edge and not before.
- R3: Outside reset, `upd_strb[i]` is 1 exactly when next-state bit i differs from `state_q[i]`.
- R4: At each rising edge outside reset, `state_q[i]` inverts when `upd_strb[i]` was 1 and otherwise keeps its value.
- R5: `state_q` equals, in every cycle, the state of a conventional register loaded each cycle with the same next-state function of the synchronised inputs.
- R6: Next value of state bit 0 = (x0 & ~x1) | (~x1 & s0) | (~x1 & s1), where x0 = synchronised `in_raw[0]`, x1 = synchronised `in_raw[1]`, s0 = `state_q[0]` and s1 = `state_q[1]`.
- R7: Next value of state bit 1 = (x0 & x1) | (~x0 & s1), with the names of R6.
- R8: `out_z` = s1 | (~x0 & s0) | (~x1 & s0), combinational from the synchronised inputs and the present state.
- R9: At each rising edge outside reset, `upd_cnt` increases by the number of ones in `upd_strb`, modulo 2^`CNT_W` (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_raw | input | 2 | Unsynchronised primary inputs, bit 0 = x0, bit 1 = x1 |
| state_q | output | 2 | Present state vector, bit 0 = s0 |
| upd_strb | output | 2 | Per-bit update strobes (bit fires when next differs from present) |
| out_z | output | 1 | Machine output |
| upd_cnt | output | CNT_W | Wrapping total of fired strobes |

## Verification
A toggle cell that misses a strobe or fires without one holds an inverted bit. From then on the bit differs from the conventional-register model at the next sampling point. A wrong strobe is already visible in the same cycle, because `upd_strb` is compared combinationally against the model's present/next mismatch. An error in the synchroniser depth moves the first strobe by one cycle after an input change. A counting error shows in `upd_cnt` one edge after the strobe that was miscounted, and it stays visible until the next reset.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

    localparam int NIN  = 2;
    localparam int NST  = 2;
    localparam int PC_W = $clog2(NST + 1);

    typedef logic [NIN-1:0] in_vec_t;
    typedef logic [NST-1:0] st_vec_t;

    typedef struct packed {
        logic x1;
        logic x0;
    } in_fields_t;

    function automatic st_vec_t next_fn(input in_vec_t iv, input st_vec_t s);
        in_fields_t f;
        st_vec_t    n;
        f    = in_fields_t'(iv);
        n[0] = (f.x0 & ~f.x1) | (~f.x1 & s[0]) | (~f.x1 & s[1]);
        n[1] = (f.x0 & f.x1) | (~f.x0 & s[1]);
        return n;
    endfunction

    function automatic logic out_fn(input in_vec_t iv, input st_vec_t s);
        in_fields_t f;
        f = in_fields_t'(iv);
        return s[1] | (~f.x0 & s[0]) | (~f.x1 & s[0]);
    endfunction

    function automatic logic [PC_W-1:0] popcnt(input st_vec_t v);
        logic [PC_W-1:0] c;
        c = '0;
        for (int i = 0; i < NST; i++) begin
            c = c + PC_W'(v[i]);
        end
        return c;
    endfunction

endpackage

// File: rtl/tsr_sync.sv
module tsr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[k] <= '0;
            else     stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tsr_tbit.sv
module tsr_tbit (
    input  logic clk,
    input  logic rst,
    input  logic nxt,
    output logic q,
    output logic upd
);
    assign upd = ~rst & (nxt ^ q);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= q ^ upd;
    end
endmodule

// File: rtl/tsr_actcnt.sv
module tsr_actcnt
    import tsr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  st_vec_t          strb,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + CNT_W'(popcnt(strb));
    end
endmodule

// File: rtl/tsr_top.sv
module tsr_top
    import tsr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIN-1:0]   in_raw,
    output logic [NST-1:0]   state_q,
    output logic [NST-1:0]   upd_strb,
    output logic             out_z,
    output logic [CNT_W-1:0] upd_cnt
);
    in_vec_t in_s;
    st_vec_t next_s;

    tsr_sync #(.W(NIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (in_raw),
        .q   (in_s)
    );

    assign next_s = next_fn(in_s, state_q);
    assign out_z  = out_fn(in_s, state_q);

    for (genvar b = 0; b < NST; b++) begin : g_bit
        tsr_tbit u_tbit (
            .clk (clk),
            .rst (rst),
            .nxt (next_s[b]),
            .q   (state_q[b]),
            .upd (upd_strb[b])
        );
    end

    tsr_actcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .strb (upd_strb),
        .cnt  (upd_cnt)
    );
endmodule

// File: rtl/tsr_chk.sv
module tsr_chk
    import tsr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [NST-1:0]   state_q,
    input logic [NST-1:0]   upd_strb,
    input logic [CNT_W-1:0] upd_cnt,
    input logic [NST-1:0]   next_s
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_q == '0 && upd_cnt == '0));

    // R4
    state_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (state_q == ($past(state_q) ^ $past(upd_strb))));

    // R5
    conv_match_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (state_q == $past(next_s)));

    // R9
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (upd_cnt == CNT_W'($past(upd_cnt) + CNT_W'($countones($past(upd_strb))))));
endmodule

bind tsr_top tsr_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .state_q  (state_q),
    .upd_strb (upd_strb),
    .upd_cnt  (upd_cnt),
    .next_s   (next_s)
);

// File: tb/tb_tsr_top.sv
`timescale 1ns/1ps
module tb_tsr_top;
    localparam int SYNC = 2;
    localparam int CW   = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [1:0]    in_raw;
    logic [1:0]    state_q;
    logic [1:0]    upd_strb;
    logic          out_z;
    logic [CW-1:0] upd_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0]    rsync [SYNC];
    logic [1:0]    rstate;
    logic [CW-1:0] rcnt;
    logic [1:0]    pstate, pstrb;
    logic          prst;

    always #2 clk = ~clk;

    tsr_top #(.SYNC_STAGES(SYNC), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .in_raw(in_raw), .state_q(state_q),
        .upd_strb(upd_strb), .out_z(out_z), .upd_cnt(upd_cnt)
    );

    function automatic logic [1:0] bnext(input logic [1:0] x, input logic [1:0] s);
        logic [1:0] n;
        n[0] = (x[0] && !x[1]) || (!x[1] && (s[0] || s[1]));
        n[1] = x[0] ? x[1] : s[1];
        return n;
    endfunction

    function automatic logic bout(input logic [1:0] x, input logic [1:0] s);
        return s[1] || (s[0] && !(x[0] && x[1]));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [1:0] v);
        logic [1:0] nx, es;
        rst = r;
        in_raw = v;
        #1;
        nx = bnext(rsync[SYNC-1], rstate);
        es = r ? 2'b00 : (nx ^ rstate);
        chk(upd_strb == es, r ? "R1 strobe in reset" : "R3 strobe", 32'(upd_strb), 32'(es));
        chk(out_z == bout(rsync[SYNC-1], rstate), "R8 output", 32'(out_z), 32'(bout(rsync[SYNC-1], rstate)));
        chk(state_q[0] == rstate[0], "R5 R6 state bit0", 32'(state_q[0]), 32'(rstate[0]));
        chk(state_q[1] == rstate[1], "R5 R7 state bit1", 32'(state_q[1]), 32'(rstate[1]));
        chk(upd_cnt == rcnt, "R9 count", 32'(upd_cnt), 32'(rcnt));
        if (prst) chk(state_q == 2'b00, "R1 state after reset", 32'(state_q), 0);
        else      chk(state_q == (pstate ^ pstrb), "R4 toggle", 32'(state_q), 32'(pstate ^ pstrb));
        pstate = state_q;
        pstrb  = upd_strb;
        prst   = r;
        if (r) begin
            rstate = 2'b00;
            rcnt   = '0;
            for (int k = 0; k < SYNC; k++) rsync[k] = 2'b00;
        end else begin
            rstate = nx;
            rcnt   = rcnt + CW'(es[0]) + CW'(es[1]);
            for (int k = SYNC - 1; k > 0; k--) rsync[k] = rsync[k-1];
            rsync[0] = v;
        end
        @(negedge clk);
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=<200000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] seed;
        void'($urandom(32'h5eed_0123));
        rst = 1'b1;
        in_raw = 2'b00;
        repeat (3) @(negedge clk);
        #1;
        chk(state_q == 2'b00, "R1 reset state", 32'(state_q), 0);
        chk(upd_cnt == '0, "R1 reset count", 32'(upd_cnt), 0);
        chk(upd_strb == 2'b00, "R1 reset strobe", 32'(upd_strb), 0);
        rstate = 2'b00; rcnt = '0; pstate = 2'b00; pstrb = 2'b00; prst = 1'b1;
        for (int k = 0; k < SYNC; k++) rsync[k] = 2'b00;

        step(1'b1, 2'b00);
        step(1'b0, 2'b01);
        step(1'b0, 2'b01);
        rst = 1'b0; #1;
        chk(upd_strb == 2'b01, "R2 strobe after sync delay", 32'(upd_strb), 32'h1);
        step(1'b0, 2'b01);
        step(1'b0, 2'b01);
        // held inputs: state settles, no rewrites fire strobes
        for (int i = 0; i < 4; i++) step(1'b0, 2'b01);
        #1;
        chk(upd_strb == 2'b00, "R3 no strobe at steady state", 32'(upd_strb), 0);
        for (int i = 0; i < 4; i++) step(1'b0, 2'b11);
        for (int i = 0; i < 4; i++) step(1'b0, 2'b00);
        for (int i = 0; i < 4; i++) step(1'b0, 2'b10);
        step(1'b1, 2'b11);
        step(1'b0, 2'b11);

        for (int i = 0; i < 4000; i++) begin
            seed = $urandom;
            step((seed[11:6] == 6'd0), seed[1:0]);
        end
        for (int i = 0; i < 300; i++) step(1'b0, (i[2]) ? 2'b01 : 2'b10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule